// File: doc/BRIEF.md
# Core timer with periodic real-time tick

This block is a free-running binary counter that raises two kinds of timed events for a processor. The first is an overflow event each time the low eight counter stages wrap from all ones back to zero, which happens once every 256 input clocks. The second is a periodic real-time tick taken from one of four higher counter stages. A two-bit rate field picks the stage, so the tick period is 1024, 2048, 4096 or 8192 clocks.

Software sees one byte-wide status and control register on a simple strobe bus. A write updates the two interrupt enables and the rate field. Writing a one to either of two write-only clear bits clears the matching event flag. A read returns the flags, enables and rate one cycle after the strobe. A single interrupt request output is high while any flag is set together with its enable.

Top module: `rt_tick_timer`

## Requirements
- R1: After reset the register reads 0x03. Bit 7 is the overflow flag, bit 6 the real-time flag, bit 5 the overflow enable, bit 4 the real-time enable, bit 3 the overflow clear, bit 2 the real-time clear, and bits 1:0 the rate field.
- R2: The overflow flag sets at the clock edge where the low eight counter stages go from 0xFF to 0x00. The counter starts at zero out of reset, so the first set is on the 256th edge after reset is released, and the flag then sets every 256 clocks.
- R3: The real-time flag sets every 2^(10+rate) clocks. Rate value 0 gives 1024 clocks and value 3 gives 8192 clocks.
- R4: Writes to bits 7 and 6 have no effect on the flags, whether a one or a zero is written.
- R5: A write with bit 3 set clears the overflow flag, and a write with bit 2 set clears the real-time flag. A write with a clear bit at zero leaves that flag unchanged.
- R6: Bits 3 and 2 always read back as zero.
- R7: If a flag-set event and a clear write fall on the same clock edge, the flag ends up set.
- R8: The interrupt output is registered. It equals the OR of (overflow flag AND overflow enable) and (real-time flag AND real-time enable) as they stood one cycle earlier. It stays high until the flag is cleared or the enable is dropped.
- R9: The read data updates one cycle after a read strobe (select high, write low) and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select strobe |
| bus_wr | input | 1 | High for a write, low for a read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
If the counter, tap selection or flag state is wrong, the effect reaches the ports within one tick period. A tap at the wrong stage shows up as an interrupt interval that differs from 2^(10+rate), and an overflow decoded at the wrong stage moves the first interrupt away from edge 257. A flag that is set or cleared wrongly shows up on the next register read, and on the interrupt output one cycle after the flag changes. The bench measures the interval between interrupt rising edges at every rate setting. It also places a clear write on the exact wrap edge to expose an inverted set/clear priority.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned B_OVF_FLAG = 7;
  localparam int unsigned B_RT_FLAG  = 6;
  localparam int unsigned B_OVF_EN   = 5;
  localparam int unsigned B_RT_EN    = 4;
  localparam int unsigned B_OVF_CLR  = 3;
  localparam int unsigned B_RT_CLR   = 2;

  typedef struct packed {
    logic             ovf_en;
    logic             rt_en;
    logic [SEL_W-1:0] rate;
  } rtt_ctl_t;
endpackage

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_tick
);
  // ovf_tick is high in the cycle before the low stages wrap
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_tick = &cnt_q[OVF_W-1:0];

  // R2
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_tick |=> (cnt_q[OVF_W-1:0] == '0));
endmodule

// File: rtl/rtt_tap_sel.sv
module rtt_tap_sel #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned TAP_LOW = 9,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             rt_tick
);
  localparam int unsigned NUM_TAPS = 1 << SEL_W;

  logic [NUM_TAPS-1:0] rise;

  // a tap bit rises at the next edge when every bit below it is one
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign rise[g] = (&cnt[TAP_LOW+g-1:0]) & ~cnt[TAP_LOW+g];
  end

  assign rt_tick = rise[sel];
endmodule

// File: rtl/rtt_ctl_reg.sv
module rtt_ctl_reg
  import rtt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             ovf_tick,
  input  logic             rt_tick,
  output logic [SEL_W-1:0] rate,
  output logic [REG_W-1:0] rdata_q,
  output logic             irq_q
);
  rtt_ctl_t         ctl_q;
  logic             ovf_q, rt_q;
  logic             wr_stb, rd_stb;
  logic [REG_W-1:0] reg_img;

  assign wr_stb = bus_sel & bus_wr;
  assign rd_stb = bus_sel & ~bus_wr;
  assign rate   = ctl_q.rate;

  always_comb begin
    reg_img             = '0;
    reg_img[B_OVF_FLAG] = ovf_q;
    reg_img[B_RT_FLAG]  = rt_q;
    reg_img[B_OVF_EN]   = ctl_q.ovf_en;
    reg_img[B_RT_EN]    = ctl_q.rt_en;
    reg_img[SEL_W-1:0]  = ctl_q.rate;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '{ovf_en: 1'b0, rt_en: 1'b0, rate: '1};
      ovf_q   <= 1'b0;
      rt_q    <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_stb) begin
        ctl_q.ovf_en <= bus_wdata[B_OVF_EN];
        ctl_q.rt_en  <= bus_wdata[B_RT_EN];
        ctl_q.rate   <= bus_wdata[SEL_W-1:0];
      end
      // set has priority over clear
      if (ovf_tick)                              ovf_q <= 1'b1;
      else if (wr_stb && bus_wdata[B_OVF_CLR])   ovf_q <= 1'b0;
      if (rt_tick)                               rt_q  <= 1'b1;
      else if (wr_stb && bus_wdata[B_RT_CLR])    rt_q  <= 1'b0;
      irq_q <= (ovf_q & ctl_q.ovf_en) | (rt_q & ctl_q.rt_en);
      if (rd_stb) rdata_q <= reg_img;
    end
  end

  // R7
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_tick |=> ovf_q);
  // R7
  rt_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    rt_tick |=> rt_q);
  // R5
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && bus_wdata[B_OVF_CLR] && !ovf_tick) |=> !ovf_q);
  // R5
  rt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && bus_wdata[B_RT_CLR] && !rt_tick) |=> !rt_q);
  // R4
  ovf_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (!ovf_q && !ovf_tick) |=> !ovf_q);
  // R4
  rt_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (!rt_q && !rt_tick) |=> !rt_q);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.ovf_en && !ctl_q.rt_en) |=> !irq_q);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((ovf_q && ctl_q.ovf_en) || (rt_q && ctl_q.rt_en)) |=> irq_q);
  // R6
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata_q[B_OVF_CLR:B_RT_CLR] == 2'b00);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rdata_q));
endmodule

// File: rtl/rt_tick_timer.sv
module rt_tick_timer
  import rtt_pkg::*;
#(
  parameter int unsigned OVF_W       = 8,
  parameter int unsigned RT_MIN_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int unsigned NUM_TAPS = 1 << SEL_W;
  localparam int unsigned TAP_LOW  = RT_MIN_LOG2 - 1;
  localparam int unsigned CNT_W    = TAP_LOW + NUM_TAPS;

  logic [CNT_W-1:0] cnt;
  logic             ovf_tick, rt_tick;
  logic [SEL_W-1:0] rate;

  rtt_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_q(cnt), .ovf_tick(ovf_tick)
  );

  rtt_tap_sel #(.CNT_W(CNT_W), .TAP_LOW(TAP_LOW), .SEL_W(SEL_W)) u_tap (
    .cnt(cnt), .sel(rate), .rt_tick(rt_tick)
  );

  rtt_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ovf_tick(ovf_tick), .rt_tick(rt_tick),
    .rate(rate), .rdata_q(bus_rdata), .irq_q(irq)
  );

  // R3
  rt_tap_align_chk: assert property (@(posedge clk) disable iff (rst)
    rt_tick |=> (cnt[TAP_LOW-1:0] == '0));
endmodule

// File: tb/rt_tick_timer_bench.sv
`timescale 1ns/1ps
module rt_tick_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  int         checks = 0;
  int         fails = 0;
  int         cyc = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  rt_tick_timer u_rt_tick_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk); while ((cyc % 256) != p);
  endtask

  task automatic wait_irq(input logic lvl);
    do @(negedge clk); while (irq !== lvl);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    bus_read(r);
    chk(r == 8'h03, "R1 reset value", r, 8'h03);
    chk(irq == 1'b0, "R8 irq after reset", irq, 0);
  endtask

  task automatic t_first_overflow();
    logic [7:0] r;
    bus_write(8'h23);
    wait_irq(1'b1);
    chk(cyc == 257, "R2 first overflow edge", cyc, 257);
    bus_read(r);
    chk(r == 8'hA3, "R1 layout with overflow flag", r, 8'hA3);
  endtask

  task automatic t_clear();
    logic [7:0] r;
    wait_phase(10);
    bus_write(8'h2B);
    @(negedge clk);
    chk(irq == 1'b0, "R5 irq low after clear", irq, 0);
    bus_read(r);
    chk(r == 8'h23, "R5 overflow flag cleared", r, 8'h23);
  endtask

  task automatic t_readonly();
    logic [7:0] r;
    wait_phase(10);
    bus_write(8'h0F);
    bus_write(8'hCF);
    bus_read(r);
    chk(r == 8'h03, "R4 R6 flag bits not writable, clear bits read 0", r, 8'h03);
    wait_phase(10);
    bus_write(8'h03);
    bus_read(r);
    chk(r[7] == 1'b1, "R4 zero write keeps flag", r[7], 1);
    chk(r[7] == 1'b1, "R5 zero clear bit keeps flag", r[7], 1);
  endtask

  task automatic t_set_wins();
    logic [7:0] r;
    wait_phase(10);
    bus_write(8'h0B);
    bus_read(r);
    chk(r[7] == 1'b0, "R7 precondition flag clear", r[7], 0);
    wait_phase(255);
    bus_write(8'h0B);
    bus_read(r);
    chk(r[7] == 1'b1, "R7 set wins over clear", r[7], 1);
  endtask

  task automatic t_rates();
    for (int s = 0; s < 4; s++) begin
      int t1, t2;
      logic [7:0] cmd;
      cmd = 8'h1C | 8'(s);
      bus_write(cmd);
      wait_irq(1'b1);
      bus_write(cmd);
      wait_irq(1'b0);
      wait_irq(1'b1);
      t1 = cyc;
      bus_write(cmd);
      wait_irq(1'b0);
      wait_irq(1'b1);
      t2 = cyc;
      chk((t2 - t1) == (1 << (10 + s)), $sformatf("R3 period rate %0d", s),
          t2 - t1, 1 << (10 + s));
    end
  endtask

  task automatic t_gating();
    logic [7:0] r;
    int seen;
    seen = 0;
    bus_write(8'h0F);
    repeat (8400) begin
      @(negedge clk);
      if (irq) seen++;
    end
    chk(seen == 0, "R8 no irq with enables off", seen, 0);
    wait_phase(20);
    bus_read(r);
    chk(r == 8'hC3, "R8 both flags pending", r, 8'hC3);
    bus_write(8'h13);
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq after real-time enable", irq, 1);
    seen = 0;
    repeat (50) begin
      @(negedge clk);
      if (!irq) seen++;
    end
    chk(seen == 0, "R8 irq held until cleared", seen, 0);
    wait_phase(20);
    bus_write(8'h23);
    seen = 0;
    repeat (5) begin
      @(negedge clk);
      if (!irq) seen++;
    end
    chk(seen == 0, "R8 irq from overflow source", seen, 0);
    bus_write(8'h2B);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq drops after overflow clear", irq, 0);
    bus_read(r);
    chk(r == 8'h63, "R5 only overflow flag cleared", r, 8'h63);
  endtask

  task automatic t_read_hold();
    logic [7:0] r;
    bus_read(r);
    repeat (300) @(negedge clk);
    chk(bus_rdata == r, "R9 read data holds without strobe", bus_rdata, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_overflow();
    t_clear();
    t_readonly();
    t_set_wins();
    t_rates();
    t_gating();
    t_read_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0x%0h expected=0x0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule